// File: doc/BRIEF.md
# Speculative Read-Set Tracker for a Set-Associative Tag Array

This block is the tag side of a private, set-associative data cache. Every line carries a single speculative-read flag. While a speculative region runs, protected loads set the flag on the line they touch, so the set of flagged lines is the region's read set. The data array, the coherence state machine and the backup of speculative writes sit in other blocks. This block watches only reads.

A region is lost when a line in its read set leaves the cache. This happens in two ways. A remote write probe can hit the line, or a miss can need a way in a set whose ways are all flagged. In either case the block raises a one-cycle abort and clears every flag. When the region ends, whether by commit or abort, a strobe clears all flags in a single cycle.

Victim choice is tuned to keep the region alive. The victim is an invalid way if one exists, otherwise an unflagged way. The block aborts only when it has no such way. The cache is assumed to serve one hardware thread.

Top module: `readset_tracker`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid and unflagged, and `abort_o` and `lk_done_o` are low.
- R2: The address splits into three fields. Bits [5:0] are the line offset, bits [9:6] are the set index and bits [31:10] are the tag. A lookup reports `lk_done_o`, `lk_hit_o`, `lk_way_o` and `lk_marked_o` one cycle later. A miss fills the chosen way with the new tag.
- R3: A lookup with `lk_protected` high sets the flag of the line it hits or fills. `lk_marked_o` gives the flag state of the hit line before the access, and is 0 on a miss.
- R4: A lookup with `lk_protected` low leaves the flag of the line unchanged.
- R5: A write probe (`sn_write`=1) that hits a flagged line invalidates the line and drives `abort_o` high in the next cycle.
- R6: A write probe that hits an unflagged line invalidates the line without an abort.
- R7: A read probe (`sn_write`=0) changes no line and no flag, and does not abort.
- R8: On a miss, the victim is the lowest-numbered invalid way. If every way is valid, the victim is the lowest-numbered unflagged way, and there is no abort.
- R9: A miss in a set whose ways are all valid and flagged replaces way 0 with its flag clear and drives `abort_o` high in the next cycle.
- R10: A `region_end` strobe clears every flag by the next cycle.
- R11: Every abort clears all flags, and `abort_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup/fill request |
| lk_addr | input | 32 | Lookup byte address |
| lk_protected | input | 1 | Lookup is a protected speculative access |
| sn_valid | input | 1 | Remote probe present |
| sn_addr | input | 32 | Probe byte address |
| sn_write | input | 1 | 1 = remote write probe, 0 = remote read probe |
| region_end | input | 1 | Region committed or aborted: clear all flags |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_way_o | output | 2 | Way hit, or way filled on a miss |
| lk_marked_o | output | 1 | Flag of the hit line before the access |
| abort_o | output | 1 | One-cycle region abort pulse |

## Verification
Every result of this block appears exactly one clock after the request that causes it. This covers the lookup outcome, the abort from a probe or a capacity conflict, and the clearing of flags. The driver applies inputs at a falling edge and queues the expected lookup outcome. The monitor pops and compares that outcome at the next falling edge, when `lk_done_o` is high. Abort checks sample `abort_o` at that same falling edge, and sample it again one cycle later to confirm that the pulse has dropped. The effect of a probe, a strobe or an abort on the flags is then read back through later lookups, by their hit, way and prior-flag result.

// File: rtl/rst_pkg.sv
// Package: shared types for the read-set tracker.
// Assumes nothing beyond being compiled first.
package rst_pkg;
    // Registered result of one lookup.
    typedef struct packed {
        logic done;
        logic hit;
        logic marked;
    } lk_flags_t;
endpackage

// File: rtl/rst_way_match.sv
// Module: compares one tag against every way of a set.
// Assumes tags are unique per set, so at most one bit of hit_vec is set.
module rst_way_match #(
    parameter int TAG_W = 22,
    parameter int WAYS  = 4
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per-way tag comparison, gated by the valid bit.
        assign hit_vec[w] = set_valid[w] && (set_tags[w] == tag);
    end
endmodule

// File: rtl/rst_victim_pick.sv
// Module: chooses the fill way for a miss.
// Order: lowest invalid way, then lowest unflagged way, then way 0.
// full_marked is high when every way is valid and flagged.
module rst_victim_pick #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0] set_valid,
    input  logic [WAYS-1:0] set_marked,
    output logic [WAYS-1:0] grant,
    output logic            full_marked
);
    logic [WAYS-1:0] free_vec;
    logic [WAYS-1:0] clean_vec;

    assign free_vec    = ~set_valid;
    assign clean_vec   = set_valid & ~set_marked;
    assign full_marked = &(set_valid & set_marked);

    // Priority selection of a single victim way.
    always_comb begin
        grant = '0;
        if (|free_vec) begin
            for (int w = WAYS - 1; w >= 0; w--)
                if (free_vec[w]) grant = WAYS'(1) << w;
        end else if (|clean_vec) begin
            for (int w = WAYS - 1; w >= 0; w--)
                if (clean_vec[w]) grant = WAYS'(1) << w;
        end else begin
            grant = WAYS'(1);
        end
    end
endmodule

// File: rtl/rst_onehot_enc.sv
// Module: turns a one-hot (or zero) vector into a binary index.
// Assumes at most one input bit is set.
module rst_onehot_enc #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] onehot,
    output logic [W-1:0] index
);
    // OR together the indices of the set bits.
    always_comb begin
        index = '0;
        for (int i = 0; i < N; i++)
            if (onehot[i]) index = index | W'(i);
    end
endmodule

// File: rtl/readset_tracker.sv
// Module: tag array with one speculative-read flag per line.
// Protected lookups flag lines. A write probe on a flagged line, or a miss in a
// set whose ways are all flagged, aborts the region. An abort or region_end
// clears all flags. Assumes a single hardware thread. When a probe and a lookup
// arrive together, the probe's effect applies first and a fill wins over it.
module readset_tracker #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int SETS     = 16,
    parameter int WAYS     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [ADDR_W-1:0]       lk_addr,
    input  logic                    lk_protected,
    input  logic                    sn_valid,
    input  logic [ADDR_W-1:0]       sn_addr,
    input  logic                    sn_write,
    input  logic                    region_end,
    output logic                    lk_done_o,
    output logic                    lk_hit_o,
    output logic [$clog2(WAYS)-1:0] lk_way_o,
    output logic                    lk_marked_o,
    output logic                    abort_o
);
    import rst_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W - OFFSET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
    logic [SETS-1:0][WAYS-1:0]            valid_q, valid_d;
    logic [SETS-1:0][WAYS-1:0]            mark_q, mark_d;

    logic [SET_W-1:0] lk_set, sn_set;
    logic [TAG_W-1:0] lk_tag, sn_tag;
    logic [WAYS-1:0]  lk_hitv, sn_hitv, vic_grant, sn_kill, lk_kill;
    logic             lk_hit, full_marked, cap_abort, snoop_abort, abort_d;
    logic [WAY_W-1:0] way_idx;
    lk_flags_t        res_d, res_q;

    assign lk_set = lk_addr[OFFSET_W +: SET_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign sn_set = sn_addr[OFFSET_W +: SET_W];
    assign sn_tag = sn_addr[ADDR_W-1 -: TAG_W];

    rst_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lk_match (
        .set_tags(tag_q[lk_set]), .set_valid(valid_q[lk_set]),
        .tag(lk_tag), .hit_vec(lk_hitv));

    rst_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_sn_match (
        .set_tags(tag_q[sn_set]), .set_valid(valid_q[sn_set]),
        .tag(sn_tag), .hit_vec(sn_hitv));

    rst_victim_pick #(.WAYS(WAYS)) u_victim (
        .set_valid(valid_q[lk_set]), .set_marked(mark_q[lk_set]),
        .grant(vic_grant), .full_marked(full_marked));

    assign lk_hit = |lk_hitv;

    rst_onehot_enc #(.N(WAYS), .W(WAY_W)) u_enc (
        .onehot(lk_hit ? lk_hitv : vic_grant), .index(way_idx));

    // Abort sources: a write probe on a flagged line, or a miss with no unflagged way.
    assign sn_kill     = (sn_valid && sn_write) ? sn_hitv : '0;
    assign lk_kill     = (sn_set == lk_set) ? sn_kill : '0;
    assign snoop_abort = |(sn_kill & mark_q[sn_set]);
    assign cap_abort   = lk_valid && !lk_hit && full_marked;
    assign abort_d     = snoop_abort || cap_abort;

    // Next-state of tags, valid and flag bits: probe, then lookup, then flash-clear.
    always_comb begin
        tag_d   = tag_q;
        valid_d = valid_q;
        mark_d  = mark_q;
        valid_d[sn_set] = valid_d[sn_set] & ~sn_kill;
        mark_d[sn_set]  = mark_d[sn_set] & ~sn_kill;
        if (lk_valid) begin
            if (lk_hit) begin
                if (lk_protected)
                    mark_d[lk_set] = mark_d[lk_set] | (lk_hitv & ~lk_kill);
            end else begin
                for (int w = 0; w < WAYS; w++) begin
                    if (vic_grant[w]) begin
                        tag_d[lk_set][w]   = lk_tag;
                        valid_d[lk_set][w] = 1'b1;
                        mark_d[lk_set][w]  = lk_protected;
                    end
                end
            end
        end
        if (abort_d || region_end)
            mark_d = '0;
    end

    // Lookup result captured for the following cycle.
    always_comb begin
        res_d.done   = lk_valid;
        res_d.hit    = lk_valid && lk_hit;
        res_d.marked = lk_valid && |(lk_hitv & mark_q[lk_set]);
    end

    // State and output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            valid_q  <= '0;
            mark_q   <= '0;
            res_q    <= '0;
            lk_way_o <= '0;
            abort_o  <= 1'b0;
        end else begin
            tag_q    <= tag_d;
            valid_q  <= valid_d;
            mark_q   <= mark_d;
            res_q    <= res_d;
            lk_way_o <= way_idx;
            abort_o  <= abort_d;
        end
    end

    assign lk_done_o   = res_q.done;
    assign lk_hit_o    = res_q.hit;
    assign lk_marked_o = res_q.marked;

    // ---------------- assertions ----------------
    assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done_o);

    assert_probe_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_valid && sn_write && |(sn_hitv & mark_q[sn_set])) |=> abort_o);

    assert_read_probe_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_valid && !sn_write && !lk_valid && !region_end)
        |=> ($stable(mark_q) && $stable(valid_q) && !abort_o));

    assert_spare_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !full_marked)
        |-> ((vic_grant & valid_q[lk_set] & mark_q[lk_set]) == '0));

    assert_end_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        region_end |=> (mark_q == '0));

    assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (mark_q == '0));

    assert_abort_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
endmodule

// File: tb/test_readset_tracker.sv
// Scoreboard bench: the driver queues expected lookup results and the monitor
// compares them at the falling edge after the design's output register loads.
module test_readset_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_protected = 1'b0;
    logic [31:0] lk_addr = '0, sn_addr = '0;
    logic        sn_valid = 1'b0, sn_write = 1'b0, region_end = 1'b0;
    logic        lk_done_o, lk_hit_o, lk_marked_o, abort_o;
    logic [1:0]  lk_way_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       hit;
        logic [1:0] way;
        logic       marked;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    readset_tracker i_readset_tracker (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_protected(lk_protected),
        .sn_valid(sn_valid), .sn_addr(sn_addr), .sn_write(sn_write),
        .region_end(region_end),
        .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_way_o(lk_way_o),
        .lk_marked_o(lk_marked_o), .abort_o(abort_o));

    function automatic logic [31:0] mk(input int tag, input int set);
        return {22'(tag), 4'(set), 6'h0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each lookup result.
    always @(negedge clk) begin
        if (rst_n && lk_done_o && !finished) begin
            if (sb.size() == 0) begin
                check("R2 unexpected result", 8'd1, 8'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " hit"}, 8'(lk_hit_o), 8'(e.hit));
                check({e.req, " way"}, 8'(lk_way_o), 8'(e.way));
                check({e.req, " marked"}, 8'(lk_marked_o), 8'(e.marked));
            end
        end
    end

    // Driver: one lookup; returns at the falling edge where the result is visible.
    task automatic lookup(input logic [31:0] a, input logic prot, input logic eh,
                          input logic [1:0] ew, input logic em, input string req);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_protected = prot;
        e.hit = eh; e.way = ew; e.marked = em; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0; lk_protected = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic wr);
        @(negedge clk);
        sn_valid = 1'b1; sn_addr = a; sn_write = wr;
        @(negedge clk);
        sn_valid = 1'b0; sn_write = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 abort after reset", 8'(abort_o), 8'd0);
        check("R1 done after reset", 8'(lk_done_o), 8'd0);
        rst_n = 1'b1;

        // Set 0: fill and flag A, fill B without a flag.
        lookup(mk(1, 0), 1'b1, 1'b0, 2'd0, 1'b0, "R2 miss fills way0");
        lookup(mk(1, 0), 1'b0, 1'b1, 2'd0, 1'b1, "R3 protected fill flags");
        lookup(mk(2, 0), 1'b0, 1'b0, 2'd1, 1'b0, "R2 second fill way1");
        lookup(mk(2, 0), 1'b0, 1'b1, 2'd1, 1'b0, "R4 unprotected leaves flag");

        // Read probe on a flagged line: no effect.
        probe(mk(1, 0), 1'b0);
        check("R7 read probe no abort", 8'(abort_o), 8'd0);
        lookup(mk(1, 0), 1'b0, 1'b1, 2'd0, 1'b1, "R7 read probe keeps line and flag");

        // Write probe on an unflagged line: invalidate, no abort.
        probe(mk(2, 0), 1'b1);
        check("R6 write probe unflagged no abort", 8'(abort_o), 8'd0);
        lookup(mk(2, 0), 1'b1, 1'b0, 2'd1, 1'b0, "R6 line invalidated, R8 invalid way reused");

        // Both lines are flagged now; a write probe on A aborts.
        probe(mk(1, 0), 1'b1);
        check("R5 write probe on flagged line aborts", 8'(abort_o), 8'd1);
        @(negedge clk);
        check("R11 abort is one cycle", 8'(abort_o), 8'd0);
        lookup(mk(2, 0), 1'b0, 1'b1, 2'd1, 1'b0, "R11 abort cleared all flags");
        lookup(mk(1, 0), 1'b0, 1'b0, 2'd0, 1'b0, "R5 flagged line invalidated");

        // Region end clears flags.
        lookup(mk(3, 1), 1'b1, 1'b0, 2'd0, 1'b0, "R3 fill set1 flagged");
        @(negedge clk);
        region_end = 1'b1;
        @(negedge clk);
        region_end = 1'b0;
        check("R10 region end no abort", 8'(abort_o), 8'd0);
        lookup(mk(3, 1), 1'b0, 1'b1, 2'd0, 1'b0, "R10 region end cleared flag");

        // Set 2: capacity behaviour.
        lookup(mk(10, 2), 1'b1, 1'b0, 2'd0, 1'b0, "R8 fill way0");
        lookup(mk(11, 2), 1'b0, 1'b0, 2'd1, 1'b0, "R8 fill way1");
        lookup(mk(12, 2), 1'b1, 1'b0, 2'd2, 1'b0, "R8 fill way2");
        lookup(mk(13, 2), 1'b1, 1'b0, 2'd3, 1'b0, "R8 fill way3");
        lookup(mk(14, 2), 1'b0, 1'b0, 2'd1, 1'b0, "R8 evict lowest unflagged way");
        check("R8 unflagged eviction no abort", 8'(abort_o), 8'd0);
        lookup(mk(14, 2), 1'b1, 1'b1, 2'd1, 1'b0, "R3 flag the way1 line");
        lookup(mk(15, 2), 1'b1, 1'b0, 2'd0, 1'b0, "R9 all flagged evicts way0");
        check("R9 capacity abort", 8'(abort_o), 8'd1);
        @(negedge clk);
        check("R11 capacity abort is one cycle", 8'(abort_o), 8'd0);
        lookup(mk(15, 2), 1'b0, 1'b1, 2'd0, 1'b0, "R9 filled line not flagged");
        lookup(mk(12, 2), 1'b0, 1'b1, 2'd2, 1'b0, "R11 capacity abort cleared flags");

        repeat (2) @(negedge clk);
        check("R2 all results consumed", 8'(sb.size()), 8'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule